// File: doc/BRIEF.md
# Two-Thread Fair Dataflow Issue Scheduler

This block is an out-of-order issue window shared by two client cores. The cores take turns at a single dispatch port. On its turn a core may hand over a group of up to four operations. Each operation carries two source tags with ready flags, a destination tag and a pipe kind. The operations wait in a common pool. Each one listens to result-tag broadcasts until both of its sources are available.

Every cycle the scheduler looks at each of four execution pipes. It picks at most one ready operation of the matching kind for each pipe that is not busy. Operations from both threads may leave in the same cycle. A single phase bit, flipped every clock, decides whose dispatch turn it is and which thread is favoured in pipe contention. Each core is told how many of its operations left the pool in the cycle. A per-thread flush discards that thread's waiting work at once.

Top module: `duo_issue_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the pool is empty, no pipe receives an operation, both completion counts are zero and the dispatch turn belongs to thread 0.
- R2: The dispatch turn output equals the phase bit. The phase bit is 0 in the first cycle after reset and flips every cycle. A group tagged with the other thread is dropped (take low) and never reaches a pipe.
- R3: A group is taken only if the pool has at least as many free entries as the group has valid lanes. Otherwise take is low and nothing enters. A group with no valid lane is never taken.
- R4: An operation becomes eligible in the cycle after it enters the pool, once both sources are ready. A source is ready if its dispatch flag was 1, or if its tag matched a valid wakeup broadcast in any cycle from its dispatch cycle onward. A wakeup makes the operation eligible from the next cycle.
- R5: Kind bit 0 steers an operation to pipes 0 or 1. Kind bit 1 steers it to pipes 2 or 3. Pipes are filled in rising index order, so an operation goes to the lowest suitable free pipe not already taken this cycle.
- R6: A pipe whose busy input is high receives no operation in that cycle.
- R7: Up to four operations issue per cycle, one per pipe, and one cycle may carry operations of both threads.
- R8: Pipes 0 and 2 favour the thread equal to the phase bit. Pipes 1 and 3 favour the other thread. A pipe serves its favoured thread if that thread has an eligible operation for it, and otherwise serves the other thread.
- R9: Within one thread, the oldest eligible operation of a kind is taken first. An earlier group is older, and inside a group a lower lane is older.
- R10: A high flush bit for a thread removes all of that thread's entries at the next edge. None of them issues in the flush cycle or later. A dispatch by that thread in the same cycle is refused. The other thread is unaffected.
- R11: For each thread, the completion count equals the number of pipes that receive that thread's operations in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_tid | input | 1 | Thread presenting the dispatch group |
| disp_vld | input | 4 | Valid flag per lane |
| disp_kind | input | 4 | Pipe kind per lane (0 multiply-accumulate, 1 integer/permute) |
| disp_rdy0 | input | 4 | First source already available, per lane |
| disp_rdy1 | input | 4 | Second source already available, per lane |
| disp_src0 | input | 4x6 | First source tag per lane |
| disp_src1 | input | 4x6 | Second source tag per lane |
| disp_dst | input | 4x6 | Destination tag per lane |
| disp_turn | output | 1 | Thread whose dispatch turn it is |
| disp_take | output | 1 | Group accepted this cycle |
| wake_vld | input | 4 | Valid flag per result broadcast |
| wake_tag | input | 4x6 | Broadcast result tags |
| pipe_busy | input | 4 | Pipe cannot accept this cycle |
| flush | input | 2 | Per-thread discard request |
| iss_vld | output | 4 | Operation sent to pipe |
| iss_tid | output | 4 | Thread of the operation sent to each pipe |
| iss_dst | output | 4x6 | Destination tag sent to each pipe |
| cmpl_cnt | output | 2x3 | Per-thread count of operations leaving the pool |

## Verification
Two pairs of functions can hit the same cycle. The first pair is thread contention for a pipe and a busy pipe. Operations of both threads are parked behind busy pipes, and then a single pipe is freed in a known phase. The favoured thread must take it, and the other thread must follow one cycle later. The second pair is a wakeup and a flush of the same entries. The broadcast and the flush arrive together, and the woken operations must never reach a pipe while the other thread's work still issues. Older-first order across groups is judged after the pool has been filled to capacity and drained under the fairness rule.

// File: rtl/dis_pkg.sv
package dis_pkg;
  typedef enum logic {
    KIND_MAC = 1'b0,
    KIND_INT = 1'b1
  } pipe_kind_e;
endpackage

// File: rtl/dis_alloc.sv
module dis_alloc #(
  parameter int ENTRIES = 16,
  parameter int LANES   = 4,
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [ENTRIES-1:0]         free_mask,
  input  logic [LANES-1:0]           lane_vld,
  input  logic                       go,
  output logic [ENTRIES-1:0]         new_mask,
  output logic [ENTRIES-1:0][LW-1:0] lane_of,
  output logic                       fits
);
  logic [LW-1:0] order [LANES];
  int nvl, nfree, k;

  always_comb begin
    nvl = 0;
    nfree = 0;
    k = 0;
    for (int l = 0; l < LANES; l++) order[l] = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_vld[l]) begin
        order[nvl] = LW'(l);
        nvl = nvl + 1;
      end
    end
    for (int i = 0; i < ENTRIES; i++) begin
      new_mask[i] = 1'b0;
      lane_of[i]  = '0;
      if (free_mask[i]) begin
        nfree = nfree + 1;
        if (k < nvl) begin
          new_mask[i] = go;
          lane_of[i]  = order[k];
          k = k + 1;
        end
      end
    end
    fits = (nvl > 0) && (nvl <= nfree);
  end
endmodule

// File: rtl/dis_pick.sv
module dis_pick #(
  parameter int ENTRIES = 16,
  parameter int NPIPE   = 4,
  parameter int NMAC    = 2
) (
  input  logic [ENTRIES-1:0]            elig,
  input  logic [ENTRIES-1:0]            tid,
  input  logic [ENTRIES-1:0]            kind,
  input  logic [ENTRIES-1:0]            yng [ENTRIES],
  input  logic [NPIPE-1:0]              busy,
  input  logic                          phase,
  output logic [NPIPE-1:0][ENTRIES-1:0] grant
);
  import dis_pkg::*;
  logic [ENTRIES-1:0] taken;
  logic [ENTRIES-1:0] cand [2];
  logic [ENTRIES-1:0] one  [2];
  logic [ENTRIES-1:0] kmask;
  logic               fav;
  int                 sub;

  always_comb begin
    taken = '0;
    kmask = '0;
    fav   = 1'b0;
    sub   = 0;
    for (int t = 0; t < 2; t++) begin
      cand[t] = '0;
      one[t]  = '0;
    end
    for (int p = 0; p < NPIPE; p++) begin
      grant[p] = '0;
      sub   = (p < NMAC) ? p : p - NMAC;
      fav   = phase ^ sub[0];
      kmask = (p < NMAC) ? ~kind : kind;
      for (int t = 0; t < 2; t++) begin
        cand[t] = elig & ~taken & kmask & ((t == 0) ? ~tid : tid);
        one[t]  = '0;
        for (int i = 0; i < ENTRIES; i++)
          if (cand[t][i] && ((cand[t] & yng[i]) == '0)) one[t][i] = 1'b1;
      end
      if (!busy[p]) grant[p] = (|one[fav]) ? one[fav] : one[~fav];
      taken = taken | grant[p];
    end
  end
endmodule

// File: rtl/duo_issue_sched.sv
module duo_issue_sched #(
  parameter int ENTRIES = 16,
  parameter int LANES   = 4,
  parameter int NPIPE   = 4,
  parameter int NMAC    = 2,
  parameter int NWAKE   = 4,
  parameter int TAGW    = 6,
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CCW    = $clog2(NPIPE + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          disp_tid,
  input  logic [LANES-1:0]              disp_vld,
  input  logic [LANES-1:0]              disp_kind,
  input  logic [LANES-1:0]              disp_rdy0,
  input  logic [LANES-1:0]              disp_rdy1,
  input  logic [LANES-1:0][TAGW-1:0]    disp_src0,
  input  logic [LANES-1:0][TAGW-1:0]    disp_src1,
  input  logic [LANES-1:0][TAGW-1:0]    disp_dst,
  output logic                          disp_turn,
  output logic                          disp_take,
  input  logic [NWAKE-1:0]              wake_vld,
  input  logic [NWAKE-1:0][TAGW-1:0]    wake_tag,
  input  logic [NPIPE-1:0]              pipe_busy,
  input  logic [1:0]                    flush,
  output logic [NPIPE-1:0]              iss_vld,
  output logic [NPIPE-1:0]              iss_tid,
  output logic [NPIPE-1:0][TAGW-1:0]    iss_dst,
  output logic [1:0][CCW-1:0]           cmpl_cnt
);
  logic [ENTRIES-1:0] vld_q, vld_d, tid_q, tid_d, kind_q, kind_d;
  logic [ENTRIES-1:0] r0_q, r0_d, r1_q, r1_d, elig, issued, new_mask;
  logic [TAGW-1:0]    s0_q [ENTRIES], s0_d [ENTRIES];
  logic [TAGW-1:0]    s1_q [ENTRIES], s1_d [ENTRIES];
  logic [TAGW-1:0]    dst_q [ENTRIES], dst_d [ENTRIES];
  logic [ENTRIES-1:0] yng_q [ENTRIES], yng_d [ENTRIES];
  logic [ENTRIES-1:0][LW-1:0] lane_of;
  logic [NPIPE-1:0][ENTRIES-1:0] grant;
  logic phase_q, fits;

  function automatic logic tag_hit(input logic [TAGW-1:0] t);
    logic h;
    h = 1'b0;
    for (int w = 0; w < NWAKE; w++) if (wake_vld[w] && wake_tag[w] == t) h = 1'b1;
    return h;
  endfunction

  assign disp_turn = phase_q;
  assign disp_take = (disp_tid == phase_q) && fits && !flush[disp_tid];

  dis_alloc #(.ENTRIES(ENTRIES), .LANES(LANES)) u_alloc (
    .free_mask(~vld_q), .lane_vld(disp_vld), .go(disp_take),
    .new_mask(new_mask), .lane_of(lane_of), .fits(fits)
  );

  always_comb
    for (int i = 0; i < ENTRIES; i++)
      elig[i] = vld_q[i] && r0_q[i] && r1_q[i] && !flush[tid_q[i]];

  dis_pick #(.ENTRIES(ENTRIES), .NPIPE(NPIPE), .NMAC(NMAC)) u_pick (
    .elig(elig), .tid(tid_q), .kind(kind_q), .yng(yng_q),
    .busy(pipe_busy), .phase(phase_q), .grant(grant)
  );

  always_comb begin
    issued   = '0;
    cmpl_cnt = '0;
    for (int p = 0; p < NPIPE; p++) begin
      iss_vld[p] = |grant[p];
      iss_tid[p] = 1'b0;
      iss_dst[p] = '0;
      issued     = issued | grant[p];
      for (int i = 0; i < ENTRIES; i++)
        if (grant[p][i]) begin
          iss_tid[p] = tid_q[i];
          iss_dst[p] = dst_q[i];
        end
      if (iss_vld[p]) cmpl_cnt[iss_tid[p]] = cmpl_cnt[iss_tid[p]] + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_d[i]  = vld_q[i] && !issued[i] && !flush[tid_q[i]];
      tid_d[i]  = tid_q[i];
      kind_d[i] = kind_q[i];
      s0_d[i]   = s0_q[i];
      s1_d[i]   = s1_q[i];
      dst_d[i]  = dst_q[i];
      r0_d[i]   = r0_q[i] || tag_hit(s0_q[i]);
      r1_d[i]   = r1_q[i] || tag_hit(s1_q[i]);
      yng_d[i]  = yng_q[i] & ~new_mask;
      if (new_mask[i]) begin
        vld_d[i]  = 1'b1;
        tid_d[i]  = disp_tid;
        kind_d[i] = disp_kind[lane_of[i]];
        s0_d[i]   = disp_src0[lane_of[i]];
        s1_d[i]   = disp_src1[lane_of[i]];
        dst_d[i]  = disp_dst[lane_of[i]];
        r0_d[i]   = disp_rdy0[lane_of[i]] || tag_hit(disp_src0[lane_of[i]]);
        r1_d[i]   = disp_rdy1[lane_of[i]] || tag_hit(disp_src1[lane_of[i]]);
        yng_d[i]  = vld_q;
        for (int j = 0; j < ENTRIES; j++)
          if (new_mask[j] && lane_of[j] < lane_of[i]) yng_d[i][j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      phase_q <= ~phase_q;
    end
  end

  always_ff @(posedge clk) begin
    r0_q <= r0_d;
    r1_q <= r1_d;
    for (int i = 0; i < ENTRIES; i++) begin
      yng_q[i] <= yng_d[i];
      if (new_mask[i]) begin
        tid_q[i]  <= tid_d[i];
        kind_q[i] <= kind_d[i];
        s0_q[i]   <= s0_d[i];
        s1_q[i]   <= s1_d[i];
        dst_q[i]  <= dst_d[i];
      end
    end
  end
endmodule

// File: rtl/duo_issue_sched_chk.sv
module duo_issue_sched_chk #(
  parameter int NPIPE = 4,
  localparam int CCW  = $clog2(NPIPE + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 disp_tid,
  input logic                 disp_turn,
  input logic                 disp_take,
  input logic [NPIPE-1:0]     pipe_busy,
  input logic [1:0]           flush,
  input logic [NPIPE-1:0]     iss_vld,
  input logic [NPIPE-1:0]     iss_tid,
  input logic [1:0][CCW-1:0]  cmpl_cnt
);
  // R2
  turn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) !disp_turn |=> disp_turn);
  // R2
  turn_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) disp_turn |=> !disp_turn);
  // R2
  take_on_turn_chk: assert property (@(posedge clk) disable iff (!rst_n) disp_take |-> disp_tid == disp_turn);
  // R11
  cmpl_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_vld) == int'(cmpl_cnt[0]) + int'(cmpl_cnt[1]));

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    // R6
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) pipe_busy[p] |-> !iss_vld[p]);
    // R10
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n) iss_vld[p] |-> !flush[iss_tid[p]]);
  end
endmodule

bind duo_issue_sched duo_issue_sched_chk #(.NPIPE(NPIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_tid(disp_tid), .disp_turn(disp_turn),
  .disp_take(disp_take), .pipe_busy(pipe_busy), .flush(flush),
  .iss_vld(iss_vld), .iss_tid(iss_tid), .cmpl_cnt(cmpl_cnt)
);

// File: tb/test_duo_issue_sched.sv
`timescale 1ns/1ps
module test_duo_issue_sched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_tid;
  logic [3:0] disp_vld, disp_kind, disp_rdy0, disp_rdy1;
  logic [3:0][5:0] disp_src0, disp_src1, disp_dst;
  logic disp_turn, disp_take;
  logic [3:0] wake_vld;
  logic [3:0][5:0] wake_tag;
  logic [3:0] pipe_busy;
  logic [1:0] flush;
  logic [3:0] iss_vld, iss_tid;
  logic [3:0][5:0] iss_dst;
  logic [1:0][2:0] cmpl_cnt;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  duo_issue_sched i_duo_issue_sched (.*);

  typedef struct packed {
    logic       tid;
    logic [3:0] vld, kind, rdy, base;
    logic       wv;
    logic [5:0] wtag;
    logic [3:0] busy;
    logic [1:0] fl;
    logic       xtake;
    logic [3:0] xvld, xtid;
    logic [23:0] xdst;
    logic [2:0] xc0, xc1;
  } vec_t;

  // Row = cycle after reset release; phase = row parity.
  localparam vec_t TBL [32] = '{
    // 0-4: turn alternation, drop of off-turn group, steering (R2 R5 R7 R9)
    '{0,4'b1111,4'b1100,4'b1111,4'd1, 0,6'd0, 4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0011,4'b0000,4'b1111,4'd2, 0,6'd0, 4'b0000,2'b00, 1,4'b1111,4'b0000,{6'd7,6'd6,6'd5,6'd4},3'd4,3'd0},
    '{0,4'b0001,4'b0000,4'b1111,4'd3, 0,6'd0, 4'b0000,2'b00, 1,4'b0011,4'b0011,{6'd0,6'd0,6'd9,6'd8},3'd0,3'd2},
    '{0,4'b1111,4'b0000,4'b1111,4'd4, 0,6'd0, 4'b0000,2'b00, 0,4'b0001,4'b0000,{6'd0,6'd0,6'd0,6'd12},3'd1,3'd0},
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    // 5-13: contention under busy pipes, both phases (R6 R8)
    '{1,4'b0001,4'b0000,4'b1111,4'd5, 0,6'd0, 4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b0001,4'b0000,4'b1111,4'd6, 0,6'd0, 4'b0011,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0010,2'b00, 0,4'b0001,4'b0001,{6'd0,6'd0,6'd0,6'd20},3'd0,3'd1},
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0001,4'b0000,{6'd0,6'd0,6'd0,6'd24},3'd1,3'd0},
    '{1,4'b0001,4'b0000,4'b1111,4'd7, 0,6'd0, 4'b0011,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b0001,4'b0000,4'b1111,4'd8, 0,6'd0, 4'b0011,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0011,2'b00, 0,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0010,2'b00, 0,4'b0001,4'b0000,{6'd0,6'd0,6'd0,6'd32},3'd1,3'd0},
    '{1,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0001,4'b0001,{6'd0,6'd0,6'd0,6'd28},3'd0,3'd1},
    // 14-16: wakeup, then a mixed-thread issue cycle (R4 R7 R11)
    '{0,4'b0011,4'b0011,4'b0000,4'd9, 0,6'd50,4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0001,4'b0000,4'b1111,4'd10,1,6'd50,4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b1101,4'b0001,{6'd37,6'd36,6'd0,6'd40},3'd2,3'd1},
    // 17-20: wakeup and flush of thread 1 in one cycle (R10)
    '{1,4'b0011,4'b0000,4'b0000,4'd11,0,6'd60,4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b0001,4'b0000,4'b1111,4'd12,0,6'd0, 4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0000,4'b0000,4'b1111,4'd0, 1,6'd60,4'b0000,2'b10, 0,4'b0001,4'b0000,{6'd0,6'd0,6'd0,6'd48},3'd1,3'd0},
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    // 21-25: fill the pool, then a refused group (R3)
    '{1,4'b1111,4'b0000,4'b1111,4'd13,0,6'd0, 4'b1111,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b1111,4'b0000,4'b1111,4'd14,0,6'd0, 4'b1111,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b1111,4'b0000,4'b1111,4'd15,0,6'd0, 4'b1111,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b1111,4'b0000,4'b1111,4'd1, 0,6'd0, 4'b1111,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0001,4'b0000,4'b1111,4'd2, 0,6'd0, 4'b1111,2'b00, 0,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    // 26-31: oldest-first across groups, flush of both with refused dispatch, refill (R8 R9 R10)
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0011,4'b0010,{6'd0,6'd0,6'd52,6'd56},3'd1,3'd1},
    '{1,4'b0001,4'b0000,4'b1111,4'd2, 0,6'd0, 4'b0000,2'b11, 0,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{0,4'b1111,4'b0000,4'b1111,4'd3, 0,6'd0, 4'b0000,2'b00, 1,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0},
    '{1,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0011,4'b0000,{6'd0,6'd0,6'd13,6'd12},3'd2,3'd0},
    '{0,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0011,4'b0000,{6'd0,6'd0,6'd15,6'd14},3'd2,3'd0},
    '{1,4'b0000,4'b0000,4'b1111,4'd0, 0,6'd0, 4'b0000,2'b00, 0,4'b0000,4'b0000,{6'd0,6'd0,6'd0,6'd0},3'd0,3'd0}
  };

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    disp_tid  = v.tid;
    disp_vld  = v.vld;
    disp_kind = v.kind;
    disp_rdy0 = v.rdy;
    disp_rdy1 = 4'b1111;
    for (int l = 0; l < 4; l++) begin
      disp_src0[l] = v.rdy[l] ? 6'd0 : v.wtag;
      disp_src1[l] = 6'd1;
      disp_dst[l]  = {v.base, 2'(l)};
    end
    wake_vld  = {3'b000, v.wv};
    wake_tag  = '0;
    wake_tag[0] = v.wtag;
    pipe_busy = v.busy;
    flush     = v.fl;
  endtask

  task automatic idle_inputs();
    drive('0);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 iss_vld in reset", int'(iss_vld), 0);
    chk("R1 turn in reset", int'(disp_turn), 0);
    chk("R1 cmpl in reset", int'(cmpl_cnt), 0);
    rst_n = 1'b1;
    for (int r = 0; r < 32; r++) begin
      if (r > 0) @(negedge clk);
      drive(TBL[r]);
      #1;
      chk($sformatf("R2 turn row %0d", r), int'(disp_turn), r % 2);
      chk($sformatf("R2 R3 R10 take row %0d", r), int'(disp_take), int'(TBL[r].xtake));
      chk($sformatf("R4 R5 R6 R7 issue row %0d", r), int'(iss_vld), int'(TBL[r].xvld));
      chk($sformatf("R8 thread row %0d", r), int'(iss_tid & TBL[r].xvld), int'(TBL[r].xtid));
      for (int p = 0; p < 4; p++)
        if (TBL[r].xvld[p])
          chk($sformatf("R9 dst row %0d pipe %0d", r, p), int'(iss_dst[p]), int'(TBL[r].xdst[p*6 +: 6]));
      chk($sformatf("R11 cmpl0 row %0d", r), int'(cmpl_cnt[0]), int'(TBL[r].xc0));
      chk($sformatf("R11 cmpl1 row %0d", r), int'(cmpl_cnt[1]), int'(TBL[r].xc1));
    end
    // R1: reset in mid-run empties the pool
    @(negedge clk);
    begin
      vec_t v;
      v = '0;
      v.vld = 4'b0011; v.rdy = 4'b1111; v.base = 4'd5; v.busy = 4'b1111;
      drive(v);
    end
    #1 chk("R3 take before reset", int'(disp_take), 1);
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    #1 chk("R1 iss_vld during reset", int'(iss_vld), 0);
    chk("R1 turn during reset", int'(disp_turn), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 iss_vld after release", int'(iss_vld), 0);
    chk("R1 turn after release", int'(disp_turn), 0);
    @(negedge clk);
    #1 chk("R1 pool empty after reset", int'(iss_vld), 0);
    chk("R1 cmpl after reset", int'(cmpl_cnt), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule